// File: doc/BRIEF.md
# NVM Checksum Validate and Update Engine

This block walks the low words of a word-addressed non-volatile memory through a simple read port and forms a 16-bit additive checksum of them, with every addition wrapping modulo 2^16. The checksum target is a fixed nonzero signature, 0xBABA by default, and not zero. One word address, the checksum word (0x3F by default), closes the covered region.

A single-cycle `start` pulse, with `mode` sampled in the same cycle, launches one of two operations. With `mode` = 0 (validate), the engine reads every word from address 0 up to and including the checksum word. It passes when the wrapped total equals the signature. With `mode` = 1 (update), the engine reads only the words below the checksum word. It then writes through the write port the value that brings the total to the signature. Each operation ends with a one-cycle `done` and a 2-bit `status`. A failed read stops the operation at once. A failed write is reported.

Reads go out one at a time. The engine holds `rd_req` and `rd_addr` until the memory side answers with `rd_valid`, and only then moves to the next address. The write uses the same request-and-acknowledge scheme.

Top module: `nvm_csum_engine`

## Requirements
- R1: The running checksum is the sum of the words read so far, reduced modulo 2^16. Carries out of bit 15 are dropped.
- R2: In validate mode the engine reads addresses 0, 1, 2, … up to and including CSUM_ADDR, each exactly once, in increasing order, which is CSUM_ADDR+1 reads in all.
- R3: When a validate run completes without a read error, `status` is 2'b00 if the wrapped sum equals SIGNATURE and 2'b01 otherwise, and no write is issued.
- R4: In update mode the engine reads addresses 0 through CSUM_ADDR-1 in increasing order. It then issues exactly one write, to address CSUM_ADDR, with data SIGNATURE minus the sum modulo 2^16, and reports 2'b00 when that write is acknowledged without error. After an update, a validate run reports 2'b00.
- R5: A read answered with `rd_err` high alongside `rd_valid` ends the operation in the next cycle with `status` 2'b10. No further read is issued and no write is issued, in either mode.
- R6: A write acknowledged with `wr_err` high alongside `wr_ack` ends the operation in the next cycle with `status` 2'b11.
- R7: Only one access is outstanding at a time. `rd_req` and `wr_req` are never high together. A raised `rd_req` keeps `rd_addr` stable until `rd_valid`, and a raised `wr_req` keeps `wr_addr` and `wr_data` stable until `wr_ack`.
- R8: A `start` that arrives while `busy` is high is ignored. The running operation keeps its mode, its address sequence and its result.
- R9: Each accepted start produces exactly one `done`, lasting a single cycle. `busy` is low in the cycle `done` is high.
- R10: After reset `busy`, `done`, `rd_req` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 1 | Operation select sampled with start: 0 validate, 1 update |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result, valid with done: 00 pass, 01 mismatch, 10 read error, 11 write error |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | ADDR_W | Word address of the current read |
| rd_valid | input | 1 | Read response strobe for the presented address |
| rd_data | input | 16 | Word returned with rd_valid |
| rd_err | input | 1 | Read failure flag, qualified by rd_valid |
| wr_req | output | 1 | Write request, held until wr_ack |
| wr_addr | output | ADDR_W | Write word address (always the checksum word) |
| wr_data | output | 16 | Checksum word to be written |
| wr_ack | input | 1 | Write completion strobe |
| wr_err | input | 1 | Write failure flag, qualified by wr_ack |

## Verification
The assertions assume that the memory side behaves as follows. It raises `rd_valid` only while `rd_req` is high and `wr_ack` only while `wr_req` is high. It treats `rd_err` and `wr_err` as meaningful only together with their strobes. It drops each strobe after one cycle. The bench responder keeps to this: it answers a held request after a programmable wait, pulses the strobe for exactly one cycle, and never answers an idle port. The one stray input the bench does drive is a `start` pulse in the middle of a run, which the engine must ignore.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    ST_PASS     = 2'b00,
    ST_MISMATCH = 2'b01,
    ST_RD_ERR   = 2'b10,
    ST_WR_ERR   = 2'b11
  } csum_status_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } csum_phase_e;

  // Wrapping addition of one word into the running total.
  function automatic logic [WORD_W-1:0] csum_add(input logic [WORD_W-1:0] acc,
                                                 input logic [WORD_W-1:0] word);
    return acc + word;
  endfunction

  // Word that lifts a partial total to the signature.
  function automatic logic [WORD_W-1:0] csum_fix(input logic [WORD_W-1:0] sig,
                                                 input logic [WORD_W-1:0] partial);
    return sig - partial;
  endfunction

endpackage

// File: rtl/nvm_csum_acc.sv
module nvm_csum_acc
  import nvm_csum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sum_q,
  output logic [WORD_W-1:0] sum_nxt
);

  assign sum_nxt = csum_add(sum_q, word);

  always_ff @(posedge clk) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= '0;
    else if (add_en) sum_q <= sum_nxt;
  end

endmodule

// File: rtl/nvm_csum_ctrl.sv
module nvm_csum_ctrl
  import nvm_csum_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       CSUM_ADDR = 63,
  parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic              rd_valid,
  input  logic              rd_err,
  input  logic              wr_ack,
  input  logic              wr_err,
  input  logic [WORD_W-1:0] sum_nxt,
  output logic              clr,
  output logic              add_en,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              word_ok,
  output logic              last_word
);

  localparam logic [ADDR_W-1:0] CS_A     = ADDR_W'(CSUM_ADDR);
  localparam logic [ADDR_W-1:0] LAST_UPD = ADDR_W'(CSUM_ADDR - 1);
  localparam bit                NO_PRE   = (CSUM_ADDR == 0);

  csum_phase_e       ph_q;
  csum_status_e      st_q;
  logic              upd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_addr;
  logic              accept;
  logic              rd_fire;
  logic              wr_fire;

  assign accept    = start && (ph_q == PH_IDLE);
  assign rd_fire   = (ph_q == PH_READ) && rd_valid;
  assign wr_fire   = (ph_q == PH_WRITE) && wr_ack;
  assign word_ok   = rd_fire && !rd_err;
  assign last_addr = upd_q ? LAST_UPD : CS_A;
  assign last_word = word_ok && (addr_q == last_addr);

  assign clr     = accept;
  assign add_en  = word_ok;
  assign rd_req  = (ph_q == PH_READ);
  assign rd_addr = addr_q;
  assign wr_req  = (ph_q == PH_WRITE);
  assign wr_addr = CS_A;
  assign busy    = (ph_q != PH_IDLE);
  assign status  = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      st_q    <= ST_PASS;
      upd_q   <= 1'b0;
      addr_q  <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            upd_q  <= mode;
            addr_q <= '0;
            if (mode && NO_PRE) begin
              wr_data <= SIGNATURE;
              ph_q    <= PH_WRITE;
            end else begin
              ph_q <= PH_READ;
            end
          end
        end
        PH_READ: begin
          if (rd_fire && rd_err) begin
            st_q <= ST_RD_ERR;
            done <= 1'b1;
            ph_q <= PH_IDLE;
          end else if (last_word) begin
            if (upd_q) begin
              wr_data <= csum_fix(SIGNATURE, sum_nxt);
              ph_q    <= PH_WRITE;
            end else begin
              st_q <= (sum_nxt == SIGNATURE) ? ST_PASS : ST_MISMATCH;
              done <= 1'b1;
              ph_q <= PH_IDLE;
            end
          end else if (word_ok) begin
            addr_q <= addr_q + 1'b1;
          end
        end
        PH_WRITE: begin
          if (wr_fire) begin
            st_q <= wr_err ? ST_WR_ERR : ST_PASS;
            done <= 1'b1;
            ph_q <= PH_IDLE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine
  import nvm_csum_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CSUM_ADDR = 63,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [15:0]       rd_data,
  input  logic              rd_err,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  input  logic              wr_ack,
  input  logic              wr_err
);

  logic              acc_clr;
  logic              acc_add;
  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] sum_nxt;
  logic              word_ok;
  logic              last_word;

  nvm_csum_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .add_en  (acc_add),
    .word    (rd_data),
    .sum_q   (sum_q),
    .sum_nxt (sum_nxt)
  );

  nvm_csum_ctrl #(
    .ADDR_W    (ADDR_W),
    .CSUM_ADDR (CSUM_ADDR),
    .SIGNATURE (SIGNATURE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .rd_valid  (rd_valid),
    .rd_err    (rd_err),
    .wr_ack    (wr_ack),
    .wr_err    (wr_err),
    .sum_nxt   (sum_nxt),
    .clr       (acc_clr),
    .add_en    (acc_add),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .word_ok   (word_ok),
    .last_word (last_word)
  );

endmodule

// File: rtl/nvm_csum_chk.sv
module nvm_csum_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CSUM_ADDR = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              rd_err,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              wr_ack,
  input logic              wr_err,
  input logic              word_ok,
  input logic              last_word
);

  localparam logic [ADDR_W-1:0] CS_A = ADDR_W'(CSUM_ADDR);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && wr_req)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R7
  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (rd_addr <= CS_A)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (word_ok && !last_word) |=> (rd_req && rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R2
  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n) wr_req |-> (wr_addr == CS_A)); // R4
  AST_RD_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && rd_valid && rd_err) |=> (done && status == 2'b10 && !rd_req && !wr_req)); // R5
  AST_WR_FAIL: assert property (@(posedge clk) disable iff (!rst_n) (wr_req && wr_ack && wr_err) |=> (done && status == 2'b11)); // R6
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !rd_valid && !wr_ack) |=> (busy && !done)); // R8

endmodule

bind nvm_csum_engine nvm_csum_chk #(
  .ADDR_W    (ADDR_W),
  .CSUM_ADDR (CSUM_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_valid  (rd_valid),
  .rd_err    (rd_err),
  .wr_req    (wr_req),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_ack    (wr_ack),
  .wr_err    (wr_err),
  .word_ok   (word_ok),
  .last_word (last_word)
);

// File: tb/nvm_csum_engine_test.sv
`timescale 1ns/1ps
module nvm_csum_engine_test;

  localparam int          AW  = 8;
  localparam int          CS  = 63;
  localparam logic [15:0] SIG = 16'hBABA;

  // vector: [21] mode, [20:19] fill pattern, [18] fix checksum word, [17:16] read latency, [15:0] seed
  localparam logic [21:0] VEC [6] = '{
    {1'b0, 2'd0, 1'b1, 2'd0, 16'h0100},
    {1'b0, 2'd1, 1'b0, 2'd1, 16'h1234},
    {1'b1, 2'd2, 1'b0, 2'd2, 16'hA5A5},
    {1'b1, 2'd3, 1'b0, 2'd0, 16'h0000},
    {1'b0, 2'd3, 1'b0, 2'd3, 16'h0000},
    {1'b0, 2'd1, 1'b1, 2'd1, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic          busy, done;
  logic [1:0]    status;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [15:0]   rd_data = '0;
  logic          rd_err = 1'b0;
  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic          wr_ack = 1'b0;
  logic          wr_err = 1'b0;

  always #2 clk = ~clk;

  nvm_csum_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .busy(busy), .done(done), .status(status),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_err(wr_err)
  );

  logic [15:0] mem [0:CS];
  int          rd_lat = 0;
  int          err_at = -1;
  bit          wr_fail = 1'b0;
  int          rd_cnt, wr_cnt, ord_bad, exp_addr, lat_cnt;
  int          last_wa;
  logic [15:0] last_wd;
  int          nvec = 0;
  int          nfail = 0;

  // memory-side responder, driven on the falling edge
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid = 1'b0;
      rd_err   = 1'b0;
    end else if (rd_req) begin
      if (lat_cnt >= rd_lat) begin
        lat_cnt = 0;
        if (int'(rd_addr) != exp_addr) ord_bad++;
        exp_addr++;
        rd_data  = (int'(rd_addr) <= CS) ? mem[rd_addr[5:0]] : 16'hDEAD;
        rd_err   = (int'(rd_addr) == err_at);
        rd_valid = 1'b1;
        rd_cnt++;
      end else begin
        lat_cnt++;
      end
    end
    if (wr_ack) begin
      wr_ack = 1'b0;
      wr_err = 1'b0;
    end else if (wr_req) begin
      wr_cnt++;
      last_wa = int'(wr_addr);
      last_wd = wr_data;
      if (!wr_fail && int'(wr_addr) <= CS) mem[wr_addr[5:0]] = wr_data;
      wr_err = wr_fail;
      wr_ack = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [1:0] pat, input logic [15:0] seed);
    for (int i = 0; i <= CS; i++) begin
      case (pat)
        2'd0: mem[i] = seed + 16'(i);
        2'd1: mem[i] = seed;
        2'd2: mem[i] = seed ^ 16'(i * 16'h1111);
        default: mem[i] = 16'hFFFF;
      endcase
    end
  endtask

  function automatic logic [15:0] model_sum(input int upto);
    logic [31:0] s = 0;
    for (int i = 0; i <= upto; i++) s = s + 32'(mem[i]);
    return s[15:0];
  endfunction

  // Launch one operation; optionally pulse start again (other mode) at cycle inj.
  task automatic run_op(input bit m, input int inj, output logic [1:0] st);
    int n = 0;
    rd_cnt = 0; wr_cnt = 0; ord_bad = 0; exp_addr = 0; lat_cnt = 0;
    last_wa = -1; last_wd = '0;
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0;
    while (!done && n < 5000) begin
      if (n == inj) begin start = 1'b1; mode = ~m; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    st = status;
    check(done == 1'b1, "R9", "done seen", int'(done), 1);
    check(busy == 1'b0, "R9", "busy low with done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", int'(done), 0);
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [1:0]  st;
    logic [15:0] s, w;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 1'b0,   "R10", "busy in reset", int'(busy), 0);
    check(done == 1'b0,   "R10", "done in reset", int'(done), 0);
    check(rd_req == 1'b0, "R10", "rd_req in reset", int'(rd_req), 0);
    check(wr_req == 1'b0, "R10", "wr_req in reset", int'(wr_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      fill(VEC[v][20:19], VEC[v][15:0]);
      rd_lat = int'(VEC[v][17:16]);
      if (!VEC[v][21]) begin
        if (VEC[v][18]) mem[CS] = SIG - model_sum(CS - 1);
        s = model_sum(CS);
        run_op(1'b0, -1, st);
        check(st == ((s == SIG) ? 2'b00 : 2'b01), "R3", "validate status", int'(st),
              (s == SIG) ? 0 : 1);
        check(rd_cnt == CS + 1, "R2", "validate read count", rd_cnt, CS + 1);
        check(ord_bad == 0, "R2", "read order", ord_bad, 0);
        check(wr_cnt == 0, "R3", "no write in validate", wr_cnt, 0);
      end else begin
        s = model_sum(CS - 1);
        w = SIG - s;
        run_op(1'b1, -1, st);
        check(st == 2'b00, "R4", "update status", int'(st), 0);
        check(rd_cnt == CS, "R4", "update read count", rd_cnt, CS);
        check(ord_bad == 0, "R4", "update read order", ord_bad, 0);
        check(wr_cnt == 1, "R4", "one write", wr_cnt, 1);
        check(last_wa == CS, "R4", "write address", last_wa, CS);
        check(last_wd == w, "R1", "written checksum (wrapped)", int'(last_wd), int'(w));
        run_op(1'b0, -1, st);
        check(st == 2'b00, "R4", "validate after update", int'(st), 0);
      end
    end

    // R5 read error in validate mode
    fill(2'd0, 16'h0042); rd_lat = 1; err_at = 20;
    run_op(1'b0, -1, st);
    check(st == 2'b10, "R5", "read error status", int'(st), 2);
    check(rd_cnt == 21, "R5", "reads stop at failure", rd_cnt, 21);
    // R5 read error in update mode: no write
    err_at = CS - 1;
    run_op(1'b1, -1, st);
    check(st == 2'b10, "R5", "update read error status", int'(st), 2);
    check(wr_cnt == 0, "R5", "no write after read error", wr_cnt, 0);
    err_at = -1;

    // R6 write error
    fill(2'd1, 16'h0777); mem[CS] = 16'h5555; wr_fail = 1'b1; rd_lat = 0;
    run_op(1'b1, -1, st);
    check(st == 2'b11, "R6", "write error status", int'(st), 3);
    check(wr_cnt == 1, "R6", "single write attempt", wr_cnt, 1);
    wr_fail = 1'b0;

    // R8 start while busy is ignored
    fill(2'd0, 16'h0300); mem[CS] = 16'h0000; rd_lat = 2;
    s = model_sum(CS);
    run_op(1'b0, 10, st);
    check(rd_cnt == CS + 1, "R8", "no restart on busy start", rd_cnt, CS + 1);
    check(ord_bad == 0, "R8", "address order unchanged", ord_bad, 0);
    check(wr_cnt == 0, "R8", "mode kept (no write)", wr_cnt, 0);
    check(st == ((s == SIG) ? 2'b00 : 2'b01), "R8", "result kept", int'(st),
          (s == SIG) ? 0 : 1);

    // R1 wrap: totals past 16 bits that land exactly on the signature
    for (int i = 0; i <= CS; i++) mem[i] = 16'hF000;
    mem[CS] = SIG - model_sum(CS - 1);
    rd_lat = 0;
    run_op(1'b0, -1, st);
    check(st == 2'b00, "R1", "wrapped sum passes", int'(st), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule